// File: doc/BRIEF.md
# Interrupt Controller Bank

This block is one bank of a memory-mapped interrupt controller. It collects a set of level-sensitive interrupt sources into sticky pending bits. It gates them with a per-source enable, and it drives one request line toward the processor together with the index of the most significant pending enabled source. Software reaches five registers through a simple 32-bit register port: the sticky pending bits, the enables, a read-only view of pending-and-enabled, a resend register that re-triggers sources, and a capture mask that selects which source inputs may set a pending bit.

Pending bits are cleared by writing ones. A source that is high at a clock edge, or whose resend bit is set, sets its pending bit again in that same cycle, and a set always wins over a clear. The request line and the index are registered, so they follow the pending and enable state one cycle later. When several sources are pending, software services the reported index, clears that bit, and reads the next index. A bank occupies a 0x28-byte window, so further banks can be placed at a 0x28 stride by the surrounding address decode.

Top module: `icu_bank`

## Requirements
- R1: After reset the pending, enable and resend registers are zero, the capture mask is all ones, `irq_o` is 0 and `irq_idx_o` is 0.
- R2: Register offsets are pending 0x00, enable 0x08, pending-and-enabled view 0x10, resend 0x18 and capture mask 0x20. A read (`bus_sel_i`=1, `bus_we_i`=0) returns the current register value, zero-extended, in the same cycle. The view at 0x10 reads pending AND enable.
- R3: Writing 1 to a bit at offset 0x00 clears that pending bit at the next edge. Writing 0 leaves it unchanged.
- R4: Source input i, when high at a clock edge while capture-mask bit i is 1, sets pending bit i at that edge. While mask bit i is 0, the input has no effect on pending bit i.
- R5: When a set (from a source or from resend) and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R6: While resend bit i is 1, pending bit i is set at every edge, whatever the source input does.
- R7: `irq_o` equals the OR of (pending AND enable) as it stood before the previous edge, so it is one register stage behind the state.
- R8: `irq_idx_o` is the position of the most significant set bit of (pending AND enable), registered together with `irq_o`. It is 0 when nothing enabled is pending.
- R9: Reads of any offset other than the five above return zero, and writes to them change nothing. Writes to the read-only view at 0x10 change nothing.
- R10: The enable, resend and capture-mask registers take the full written value at the next edge and read it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level interrupt sources, sampled at each edge |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset within the bank |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, zero when not reading or unmapped |
| irq_o | output | 1 | Registered request line to the processor |
| irq_idx_o | output | $clog2(NUM_SRC) | Registered index of the highest pending enabled source |

## Verification
The bench drives single-source pulses to show capture and the index encoding. It then drives several simultaneous sources, with the enable set both with and without the top bit, to tell the most-significant choice apart from any other priority. Clear writes that coincide with a high source or a set resend bit separate set-wins from clear-wins. Inputs on masked-off bits, and writes to unmapped or read-only offsets, show that nothing changes. A long stretch of random source levels and random bus accesses over mapped and unmapped offsets is compared every cycle against a behavioural model, which exposes ordering errors between capture, clear and the registered outputs.

// File: rtl/icu_bank_pkg.sv
package icu_bank_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_PEND   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_VIEW   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_RESEND = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_CAPMSK = 6'h20;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_ENABLE,
        SEL_VIEW,
        SEL_RESEND,
        SEL_CAPMSK
    } reg_sel_e;
endpackage

// File: rtl/icu_bank_regdec.sv
module icu_bank_regdec
    import icu_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);
    always_comb begin
        case (addr_i)
            OFS_PEND:   sel_o = SEL_PEND;
            OFS_ENABLE: sel_o = SEL_ENABLE;
            OFS_VIEW:   sel_o = SEL_VIEW;
            OFS_RESEND: sel_o = SEL_RESEND;
            OFS_CAPMSK: sel_o = SEL_CAPMSK;
            default:    sel_o = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/icu_bank_prienc.sv
module icu_bank_prienc #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    // Scan upward; the last set bit seen is the most significant one.
    always_comb begin
        idx_o = '0;
        for (int b = 0; b < WIDTH; b++) begin
            if (vec_i[b]) begin
                idx_o = IDX_W'(b);
            end
        end
        any_o = |vec_i;
    end
endmodule

// File: rtl/icu_bank.sv
module icu_bank
    import icu_bank_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o,
    output logic [IDX_W-1:0]   irq_idx_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] enable;
        logic [NUM_SRC-1:0] resend;
        logic [NUM_SRC-1:0] capmsk;
        logic               irq;
        logic [IDX_W-1:0]   idx;
    } state_t;

    state_t r_d, r_q;

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] view;
    logic [IDX_W-1:0]   top_idx;
    logic               top_any;
    logic               wr_stb;
    logic [NUM_SRC-1:0] wr_val;
    logic [NUM_SRC-1:0] clr_mask;

    icu_bank_regdec u_dec (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    assign view = r_q.pend & r_q.enable;

    icu_bank_prienc #(.WIDTH(NUM_SRC)) u_enc (
        .vec_i (view),
        .idx_o (top_idx),
        .any_o (top_any)
    );

    always_comb begin
        r_d      = r_q;
        wr_stb   = bus_sel_i && bus_we_i;
        wr_val   = bus_wdata_i[NUM_SRC-1:0];
        clr_mask = (wr_stb && sel == SEL_PEND) ? wr_val : '0;

        // Clear first, then set: a coincident set always survives.
        r_d.pend = (r_q.pend & ~clr_mask) | (src_i & r_q.capmsk) | r_q.resend;

        if (wr_stb) begin
            case (sel)
                SEL_ENABLE: r_d.enable = wr_val;
                SEL_RESEND: r_d.resend = wr_val;
                SEL_CAPMSK: r_d.capmsk = wr_val;
                default:    ;
            endcase
        end

        r_d.irq = top_any;
        r_d.idx = top_idx;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q        <= '0;
            r_q.capmsk <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i && !bus_we_i) begin
            case (sel)
                SEL_PEND:   bus_rdata_o = DATA_W'(r_q.pend);
                SEL_ENABLE: bus_rdata_o = DATA_W'(r_q.enable);
                SEL_VIEW:   bus_rdata_o = DATA_W'(view);
                SEL_RESEND: bus_rdata_o = DATA_W'(r_q.resend);
                SEL_CAPMSK: bus_rdata_o = DATA_W'(r_q.capmsk);
                default:    bus_rdata_o = '0;
            endcase
        end
    end

    assign irq_o     = r_q.irq;
    assign irq_idx_o = r_q.idx;
endmodule

// File: rtl/icu_bank_chk.sv
module icu_bank_chk
    import icu_bank_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] src_i,
    input logic               bus_sel_i,
    input logic               bus_we_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [DATA_W-1:0]  bus_wdata_i,
    input logic [DATA_W-1:0]  bus_rdata_o,
    input logic               irq_o,
    input logic [IDX_W-1:0]   irq_idx_o,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic [NUM_SRC-1:0] resend_q,
    input logic [NUM_SRC-1:0] capmsk_q
);
    logic unmapped;
    assign unmapped = bus_addr_i != OFS_PEND && bus_addr_i != OFS_ENABLE &&
                      bus_addr_i != OFS_VIEW && bus_addr_i != OFS_RESEND &&
                      bus_addr_i != OFS_CAPMSK;

    assert_clear_only_unset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && bus_we_i && bus_addr_i == OFS_PEND) |=>
        ((pend_q & $past(bus_wdata_i[NUM_SRC-1:0] & ~(src_i & capmsk_q) & ~resend_q)) == '0));

    assert_capture_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((src_i & capmsk_q) != '0) |=>
        ((pend_q & $past(src_i & capmsk_q)) == $past(src_i & capmsk_q)));

    assert_resend_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resend_q != '0) |=> ((pend_q & $past(resend_q)) == $past(resend_q)));

    assert_line_low_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pend_q & enable_q) == '0) |=> !irq_o);

    assert_index_is_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (($past(pend_q & enable_q) >> irq_idx_o) == NUM_SRC'(1)));

    assert_index_zero_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> irq_idx_o == '0);

    assert_unmapped_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && !bus_we_i && unmapped) |-> bus_rdata_o == '0);

    assert_enable_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && bus_we_i && bus_addr_i == OFS_ENABLE) |=>
        enable_q == $past(bus_wdata_i[NUM_SRC-1:0]));
endmodule

bind icu_bank icu_bank_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .irq_idx_o   (irq_idx_o),
    .pend_q      (r_q.pend),
    .enable_q    (r_q.enable),
    .resend_q    (r_q.resend),
    .capmsk_q    (r_q.capmsk)
);

// File: tb/icu_bank_tb_top.sv
`timescale 1ns/1ps
module icu_bank_tb_top;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [4:0]  idx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // behavioural model state
    bit [31:0] m_pend, m_en, m_res, m_msk;
    bit        m_irq;
    int        m_idx;

    always #4 clk = ~clk;

    icu_bank dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .bus_sel_i   (sel),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .irq_idx_o   (idx)
    );

    function automatic int top_bit(bit [31:0] v);
        int r = 0;
        for (int b = 0; b < 32; b++) if (v[b]) r = b;
        return r;
    endfunction

    function automatic bit [31:0] m_read(bit [5:0] a);
        case (a)
            6'h00: return m_pend;
            6'h08: return m_en;
            6'h10: return m_pend & m_en;
            6'h18: return m_res;
            6'h20: return m_msk;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(bit [5:0] a);
        case (a)
            6'h00: return "R3";
            6'h08: return "R10";
            6'h10: return "R2";
            6'h18: return "R6";
            6'h20: return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit [31:0] pv = m_pend & m_en;
        bit [31:0] clr = (sel && we && addr == 6'h00) ? wdata : 32'h0;
        bit [31:0] np = (m_pend & ~clr) | (src & m_msk) | m_res;
        m_irq = (pv != 0);
        m_idx = m_irq ? top_bit(pv) : 0;
        if (sel && we) begin
            if (addr == 6'h08) m_en = wdata;
            if (addr == 6'h18) m_res = wdata;
            if (addr == 6'h20) m_msk = wdata;
        end
        m_pend = np;
    endtask

    task automatic compare_all();
        chk("R7", {31'h0, irq}, {31'h0, m_irq});
        chk("R8", {27'h0, idx}, m_idx);
        if (sel && !we) chk(tag_of(addr), rdata, m_read(addr));
        else chk("R2", rdata, 32'h0);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        sel = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic wr(bit [5:0] a, bit [31:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        step();
        idle();
    endtask

    task automatic rd(bit [5:0] a, string tag, bit [31:0] exp);
        sel = 1'b1; we = 1'b0; addr = a;
        #1;
        chk(tag, rdata, exp);
        step();
        idle();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_pend = 0; m_en = 0; m_res = 0; m_msk = 32'hFFFF_FFFF; m_irq = 0; m_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", {31'h0, irq}, 32'h0);
        chk("R1", {27'h0, idx}, 32'h0);
        rd(6'h20, "R1", 32'hFFFF_FFFF);
        rd(6'h00, "R1", 32'h0);
        rd(6'h08, "R1", 32'h0);

        // init sequence
        wr(6'h08, 32'h0);
        wr(6'h00, 32'hFFFF_FFFF);
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h18, 32'h0);

        // R10 / R4 / R7 / R8: single source
        wr(6'h08, 32'h8010_00F0);
        rd(6'h08, "R10", 32'h8010_00F0);
        src = 32'h0000_0020; step(); src = '0;
        step();
        chk("R8", {27'h0, idx}, 32'd5);
        rd(6'h10, "R2", 32'h0000_0020);

        // R8: several sources, highest wins
        src = 32'h8010_0020; step(); src = '0;
        step();
        chk("R8", {27'h0, idx}, 32'd31);
        wr(6'h08, 32'h0010_00F0);
        step();
        chk("R8", {27'h0, idx}, 32'd20);

        // R3: clear bit 20, write zero keeps rest
        wr(6'h00, 32'h0010_0000);
        step();
        chk("R3", {27'h0, idx}, 32'd5);
        wr(6'h00, 32'h0);
        rd(6'h00, "R3", 32'h8000_0020);

        // R5: set and clear collide
        src = 32'h0000_0080;
        wr(6'h00, 32'h0000_0080);
        src = '0;
        rd(6'h00, "R5", 32'h8000_00A0);

        // R6: resend holds bit 3 against clears
        wr(6'h18, 32'h0000_0008);
        wr(6'h00, 32'h0000_0008);
        rd(6'h00, "R6", 32'h8000_00A8);
        wr(6'h18, 32'h0);
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, "R6", 32'h0);
        step();
        chk("R7", {31'h0, irq}, 32'h0);

        // R4: masked source ignored
        wr(6'h20, 32'hFFFF_FDFF);
        src = 32'h0000_0200; step(); step(); src = '0;
        rd(6'h00, "R4", 32'h0);
        wr(6'h20, 32'hFFFF_FFFF);

        // R9: unmapped and read-only offsets
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h28, 32'hFFFF_FFFF);
        wr(6'h10, 32'hFFFF_FFFF);
        rd(6'h04, "R9", 32'h0);
        rd(6'h3C, "R9", 32'h0);
        rd(6'h08, "R9", 32'h0010_00F0);
        rd(6'h18, "R9", 32'h0);

        // random traffic, compared every cycle
        for (int k = 0; k < 3000; k++) begin
            bit [5:0] offs [8] = '{6'h00, 6'h08, 6'h10, 6'h18, 6'h20, 6'h04, 6'h2C, 6'h00};
            src   = $urandom() & $urandom() & $urandom();
            sel   = ($urandom() % 2) == 0;
            we    = ($urandom() % 3) == 0;
            addr  = offs[$urandom() % 8];
            wdata = $urandom();
            if (addr == 6'h18) wdata = wdata & $urandom() & $urandom();
            step();
        end
        idle(); src = '0;
        step();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule